// File: doc/BRIEF.md
# Register Rename and Reorder-Buffer Allocation Stage

This block sits between decode and the issue queues of an out-of-order core. Each cycle it takes a group of up to `WIDTH` decoded micro-ops. Each op names three source architectural registers and one destination register. Every valid op is given a reorder-buffer sequence number. Each source is translated to a physical tag through an alias table, along with a flag that says whether the value already sits in the physical register file. Each op that writes a register draws a fresh physical tag from a free list. The op also reports the tag that the destination held before, so that later stages can release it.

Ops within a group are renamed as if they were processed one after another. A source that reads a register written by an earlier op of the same group gets that op's new tag and is reported as not yet available. The whole group is held back when there are too few free physical tags or too few reorder-buffer entries. Writeback ports mark tags as available. Retire logic hands freed tags back through a return port.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register a maps to physical tag a, every physical tag is available, and the first sequence number handed out is 0.
- R2: Valid ops get consecutive sequence numbers in slot order, modulo ROB_DEPTH. Invalid slots take none. The count carries over from one accepted group to the next.
- R3: A nonzero source that no earlier op of its group writes returns the tag the alias table currently holds for it. Its availability flag equals that tag's ready bit.
- R4: Each valid op whose destination is not register 0 receives the oldest free tag, taken in slot order. After reset the free tags are handed out as ARCH_REGS, ARCH_REGS+1, … up to PHYS_REGS-1. Returned tags are queued behind them, in return-port order.
- R5: When a source reads the destination of an earlier op in the same group, it takes the new tag of the latest such op and is marked not available.
- R6: Register 0 is never renamed. As a source it returns tag 0 with availability 1. As a destination it consumes no free tag and reports tag 0.
- R7: The group stalls when the tags it needs exceed the free-list count, or when its valid ops exceed `rob_free`. During a stall `stall` is 1, `out_valid` is all zero, and the alias table, free list and sequence counter keep their state.
- R8: A writeback makes its tag available from the next cycle on. A tag handed out by an accepted group becomes unavailable from the next cycle on.
- R9: `out_old_tag` carries the destination's previous mapping, and that mapping includes any write by an earlier op of the same group.
- R10: A tag returned in a given cycle cannot be allocated in that same cycle. The stall decision uses the free-list count registered at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | WIDTH | Slot holds a decoded op |
| in_src | input | WIDTH×3×AREG_W | Source architectural registers A, B, C per slot |
| in_dst | input | WIDTH×AREG_W | Destination architectural register (0 = none) |
| rob_free | input | ROBC_W | Free reorder-buffer entries this cycle |
| wb_valid | input | WB_PORTS | Writeback strobe per port |
| wb_tag | input | WB_PORTS×PTAG_W | Physical tag written back |
| ret_valid | input | RET_PORTS | Freed-tag return strobe per port |
| ret_tag | input | RET_PORTS×PTAG_W | Physical tag returned to the free list |
| stall | output | 1 | Group held back this cycle |
| out_valid | output | WIDTH | Renamed op valid |
| out_seq | output | WIDTH×SEQ_W | Reorder-buffer sequence number |
| out_src_tag | output | WIDTH×3×PTAG_W | Physical tag per source |
| out_src_avail | output | WIDTH×3 | Source value already in register file |
| out_dst_tag | output | WIDTH×PTAG_W | Newly allocated destination tag |
| out_old_tag | output | WIDTH×PTAG_W | Previous mapping of the destination |

## Verification
The case that needs care is a tag return and a tag allocation landing in the same cycle. It is provoked by draining the free list to zero and then presenting a group that needs one tag while a freed tag comes back on the return port. The group must stall. On the next cycle the same group must receive exactly the returned tag. Every random cycle of a longer run also mixes intra-group bypass, writebacks and stalls. Each output field is compared against a sequential model that renames the slots one by one.

// File: rtl/rn_pkg.sv
package rn_pkg;

    // Source operands per micro-op: A, B, C.
    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        SRC_A = 2'd0,
        SRC_B = 2'd1,
        SRC_C = 2'd2
    } src_slot_e;

    // Advance a ring pointer by inc positions in a ring of the given depth.
    function automatic int unsigned ring_add(input int unsigned base,
                                             input int unsigned inc,
                                             input int unsigned depth);
        return (base + inc) % depth;
    endfunction

endpackage

// File: rtl/rn_alias_table.sv
module rn_alias_table
    import rn_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter int ARCH_REGS = 32,
    parameter int PHYS_REGS = 64,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [WIDTH-1:0][NUM_SRC-1:0][AW-1:0]  src_idx,
    output logic [WIDTH-1:0][NUM_SRC-1:0][PW-1:0]  src_tag,
    input  logic [WIDTH-1:0][AW-1:0]               dst_idx,
    output logic [WIDTH-1:0][PW-1:0]               dst_tag,
    input  logic [WIDTH-1:0]                       wr_en,
    input  logic [WIDTH-1:0][PW-1:0]               wr_tag
);

    logic [ARCH_REGS-1:0][PW-1:0] map_q;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                src_tag[i][s] = map_q[src_idx[i][s]];
            end
            dst_tag[i] = map_q[dst_idx[i]];
        end
    end

    // Writes in slot order: a later slot to the same register wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < ARCH_REGS; a++) begin
                map_q[a] <= PW'(a);
            end
        end else begin
            for (int i = 0; i < WIDTH; i++) begin
                if (wr_en[i]) begin
                    map_q[dst_idx[i]] <= wr_tag[i];
                end
            end
        end
    end

    // R6: the zero register keeps its fixed mapping.
    a_r6_zero_fixed: assert property (@(posedge clk) disable iff (rst)
        map_q[0] == '0);

endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
    import rn_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter int ARCH_REGS = 32,
    parameter int PHYS_REGS = 64,
    parameter int RET_PORTS = 2,
    localparam int PW    = $clog2(PHYS_REGS),
    localparam int DEPTH = PHYS_REGS - ARCH_REGS,
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int NW    = $clog2(WIDTH + 1),
    localparam int RW    = $clog2(RET_PORTS + 1)
) (
    input  logic                            clk,
    input  logic                            rst,
    output logic [WIDTH-1:0][PW-1:0]        head_tag,
    output logic [CW-1:0]                   count,
    input  logic [NW-1:0]                   pop_n,
    input  logic [RET_PORTS-1:0]            push_en,
    input  logic [RET_PORTS-1:0][PW-1:0]    push_tag
);

    logic [DEPTH-1:0][PW-1:0]   slots_q;
    logic [IW-1:0]              head_q, tail_q;
    logic [CW-1:0]              count_q;
    logic [RET_PORTS-1:0][IW-1:0] push_pos;
    logic [RW-1:0]              push_tot;

    assign count = count_q;

    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            head_tag[k] = slots_q[IW'(ring_add(32'(head_q), k, DEPTH))];
        end
    end

    always_comb begin
        int unsigned n;
        n = 0;
        for (int r = 0; r < RET_PORTS; r++) begin
            push_pos[r] = IW'(ring_add(32'(tail_q), n, DEPTH));
            if (push_en[r]) begin
                n = n + 1;
            end
        end
        push_tot = RW'(n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                slots_q[k] <= PW'(ARCH_REGS + k);
            end
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= CW'(DEPTH);
        end else begin
            for (int r = 0; r < RET_PORTS; r++) begin
                if (push_en[r]) begin
                    slots_q[push_pos[r]] <= push_tag[r];
                end
            end
            head_q  <= IW'(ring_add(32'(head_q), 32'(pop_n), DEPTH));
            tail_q  <= IW'(ring_add(32'(tail_q), 32'(push_tot), DEPTH));
            count_q <= CW'(32'(count_q) - 32'(pop_n) + 32'(push_tot));
        end
    end

    // R7: never hands out more tags than it holds.
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        32'(pop_n) <= 32'(count_q));

    // R4: occupancy never exceeds the ring.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        32'(count_q) <= DEPTH);

endmodule

// File: rtl/rn_ready_table.sv
module rn_ready_table
    import rn_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter int PHYS_REGS = 64,
    parameter int WB_PORTS  = 2,
    localparam int PW = $clog2(PHYS_REGS)
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [WIDTH-1:0][NUM_SRC-1:0][PW-1:0]  rd_tag,
    output logic [WIDTH-1:0][NUM_SRC-1:0]          rd_ready,
    input  logic [WB_PORTS-1:0]                    set_en,
    input  logic [WB_PORTS-1:0][PW-1:0]            set_tag,
    input  logic [WIDTH-1:0]                       clr_en,
    input  logic [WIDTH-1:0][PW-1:0]               clr_tag
);

    logic [PHYS_REGS-1:0] rdy_q;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                rd_ready[i][s] = rdy_q[rd_tag[i][s]];
            end
        end
    end

    // Writebacks set, fresh allocations clear; a clear takes precedence.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q <= '1;
        end else begin
            for (int p = 0; p < WB_PORTS; p++) begin
                if (set_en[p]) begin
                    rdy_q[set_tag[p]] <= 1'b1;
                end
            end
            for (int i = 0; i < WIDTH; i++) begin
                if (clr_en[i]) begin
                    rdy_q[clr_tag[i]] <= 1'b0;
                end
            end
        end
    end

    // R8: an allocated tag reads as busy on the following cycle.
    for (genvar i = 0; i < WIDTH; i++) begin : g_clr_chk
        a_r8_alloc_busy: assert property (@(posedge clk) disable iff (rst)
            clr_en[i] |=> !rdy_q[$past(clr_tag[i])]);
    end

endmodule

// File: rtl/rename_unit.sv
module rename_unit
    import rn_pkg::*;
#(
    parameter int WIDTH     = 4,
    parameter int ARCH_REGS = 32,
    parameter int PHYS_REGS = 64,
    parameter int ROB_DEPTH = 32,
    parameter int WB_PORTS  = 2,
    parameter int RET_PORTS = 2,
    localparam int AREG_W = $clog2(ARCH_REGS),
    localparam int PTAG_W = $clog2(PHYS_REGS),
    localparam int SEQ_W  = (ROB_DEPTH > 1) ? $clog2(ROB_DEPTH) : 1,
    localparam int ROBC_W = $clog2(ROB_DEPTH + 1)
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic [WIDTH-1:0]                             in_valid,
    input  logic [WIDTH-1:0][NUM_SRC-1:0][AREG_W-1:0]    in_src,
    input  logic [WIDTH-1:0][AREG_W-1:0]                 in_dst,
    input  logic [ROBC_W-1:0]                            rob_free,
    input  logic [WB_PORTS-1:0]                          wb_valid,
    input  logic [WB_PORTS-1:0][PTAG_W-1:0]              wb_tag,
    input  logic [RET_PORTS-1:0]                         ret_valid,
    input  logic [RET_PORTS-1:0][PTAG_W-1:0]             ret_tag,
    output logic                                         stall,
    output logic [WIDTH-1:0]                             out_valid,
    output logic [WIDTH-1:0][SEQ_W-1:0]                  out_seq,
    output logic [WIDTH-1:0][NUM_SRC-1:0][PTAG_W-1:0]    out_src_tag,
    output logic [WIDTH-1:0][NUM_SRC-1:0]                out_src_avail,
    output logic [WIDTH-1:0][PTAG_W-1:0]                 out_dst_tag,
    output logic [WIDTH-1:0][PTAG_W-1:0]                 out_old_tag
);

    localparam int FL_DEPTH = PHYS_REGS - ARCH_REGS;
    localparam int FL_CW    = $clog2(FL_DEPTH + 1);
    localparam int CNT_W    = $clog2(WIDTH + 1);

    // Per-slot bookkeeping computed from the incoming group.
    typedef struct packed {
        logic              alloc;    // op needs a fresh tag
        logic [CNT_W-1:0]  tag_ofs;  // allocating ops before this slot
        logic [CNT_W-1:0]  seq_ofs;  // valid ops before this slot
    } slot_info_t;

    slot_info_t [WIDTH-1:0]                       info;
    logic [CNT_W-1:0]                             need_tags, need_rob;
    logic [WIDTH-1:0][NUM_SRC-1:0][PTAG_W-1:0]    map_src_tag;
    logic [WIDTH-1:0][PTAG_W-1:0]                 map_dst_tag;
    logic [WIDTH-1:0][NUM_SRC-1:0]                map_src_rdy;
    logic [WIDTH-1:0][PTAG_W-1:0]                 fl_head;
    logic [FL_CW-1:0]                             fl_count;
    logic [WIDTH-1:0][PTAG_W-1:0]                 new_tag;
    logic [WIDTH-1:0]                             commit_alloc;
    logic [SEQ_W-1:0]                             seq_q;
    logic                                         accept;

    // Prefix counts in slot order.
    always_comb begin
        int unsigned na, nv;
        na = 0;
        nv = 0;
        for (int i = 0; i < WIDTH; i++) begin
            info[i].alloc   = in_valid[i] && (in_dst[i] != '0);
            info[i].tag_ofs = CNT_W'(na);
            info[i].seq_ofs = CNT_W'(nv);
            if (info[i].alloc) na = na + 1;
            if (in_valid[i])   nv = nv + 1;
        end
        need_tags = CNT_W'(na);
        need_rob  = CNT_W'(nv);
    end

    assign stall  = (32'(need_tags) > 32'(fl_count)) ||
                    (32'(need_rob)  > 32'(rob_free));
    assign accept = !stall;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            new_tag[i]      = fl_head[info[i].tag_ofs];
            commit_alloc[i] = info[i].alloc && accept;
            out_valid[i]    = in_valid[i] && accept;
            out_seq[i]      = SEQ_W'(ring_add(32'(seq_q), 32'(info[i].seq_ofs), ROB_DEPTH));
            out_dst_tag[i]  = info[i].alloc ? new_tag[i] : '0;
        end
    end

    // Source and old-destination resolution with intra-group forwarding:
    // the latest earlier writer in the group overrides the table.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                out_src_tag[i][s]   = map_src_tag[i][s];
                out_src_avail[i][s] = map_src_rdy[i][s];
                for (int j = 0; j < i; j++) begin
                    if (info[j].alloc && (in_dst[j] == in_src[i][s])) begin
                        out_src_tag[i][s]   = new_tag[j];
                        out_src_avail[i][s] = 1'b0;
                    end
                end
                if (in_src[i][s] == '0) begin
                    out_src_tag[i][s]   = '0;
                    out_src_avail[i][s] = 1'b1;
                end
            end
            out_old_tag[i] = map_dst_tag[i];
            for (int j = 0; j < i; j++) begin
                if (info[j].alloc && (in_dst[j] == in_dst[i])) begin
                    out_old_tag[i] = new_tag[j];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '0;
        end else if (accept) begin
            seq_q <= SEQ_W'(ring_add(32'(seq_q), 32'(need_rob), ROB_DEPTH));
        end
    end

    rn_alias_table #(
        .WIDTH(WIDTH), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)
    ) u_alias (
        .clk     (clk),
        .rst     (rst),
        .src_idx (in_src),
        .src_tag (map_src_tag),
        .dst_idx (in_dst),
        .dst_tag (map_dst_tag),
        .wr_en   (commit_alloc),
        .wr_tag  (new_tag)
    );

    rn_free_list #(
        .WIDTH(WIDTH), .ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS),
        .RET_PORTS(RET_PORTS)
    ) u_free (
        .clk      (clk),
        .rst      (rst),
        .head_tag (fl_head),
        .count    (fl_count),
        .pop_n    (accept ? need_tags : '0),
        .push_en  (ret_valid),
        .push_tag (ret_tag)
    );

    rn_ready_table #(
        .WIDTH(WIDTH), .PHYS_REGS(PHYS_REGS), .WB_PORTS(WB_PORTS)
    ) u_ready (
        .clk      (clk),
        .rst      (rst),
        .rd_tag   (map_src_tag),
        .rd_ready (map_src_rdy),
        .set_en   (wb_valid),
        .set_tag  (wb_tag),
        .clr_en   (commit_alloc),
        .clr_tag  (new_tag)
    );

    for (genvar i = 1; i < WIDTH; i++) begin : g_pair_chk
        // R2: neighbouring valid ops hold consecutive sequence numbers.
        a_r2_seq_contig: assert property (@(posedge clk) disable iff (rst)
            (out_valid[i] && out_valid[i-1]) |->
            (32'(out_seq[i]) == ring_add(32'(out_seq[i-1]), 1, ROB_DEPTH)));
        for (genvar j = 0; j < i; j++) begin : g_prev
            // R4: two allocations in one group never share a tag.
            a_r4_unique_tag: assert property (@(posedge clk) disable iff (rst)
                (out_valid[i] && out_valid[j] && in_dst[i] != '0 && in_dst[j] != '0)
                |-> (out_dst_tag[i] != out_dst_tag[j]));
            for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
                // R5: a source produced earlier in the group is never ready.
                a_r5_fwd_busy: assert property (@(posedge clk) disable iff (rst)
                    (out_valid[i] && out_valid[j] && in_dst[j] != '0 &&
                     in_dst[j] == in_src[i][s]) |-> !out_src_avail[i][s]);
            end
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_zero_chk
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            // R6: the zero register reads as tag 0, always available.
            a_r6_zero_src: assert property (@(posedge clk) disable iff (rst)
                (out_valid[i] && in_src[i][s] == '0) |->
                (out_src_avail[i][s] && out_src_tag[i][s] == '0));
        end
    end

    // R7: a stalled group leaves the sequence counter untouched.
    a_r7_hold_seq: assert property (@(posedge clk) disable iff (rst)
        stall |=> (seq_q == $past(seq_q)));

endmodule

// File: tb/rename_unit_bench.sv
module rename_unit_bench;

    localparam int W   = 3;
    localparam int AR  = 8;
    localparam int PR  = 16;
    localparam int RD  = 8;
    localparam int FLD = PR - AR;
    localparam int NS  = 3;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [W-1:0]             in_valid;
    logic [W-1:0][NS-1:0][2:0] in_src;
    logic [W-1:0][2:0]        in_dst;
    logic [3:0]               rob_free;
    logic [1:0]               wb_valid;
    logic [1:0][3:0]          wb_tag;
    logic [1:0]               ret_valid;
    logic [1:0][3:0]          ret_tag;
    logic                     stall;
    logic [W-1:0]             out_valid;
    logic [W-1:0][2:0]        out_seq;
    logic [W-1:0][NS-1:0][3:0] out_src_tag;
    logic [W-1:0][NS-1:0]     out_src_avail;
    logic [W-1:0][3:0]        out_dst_tag;
    logic [W-1:0][3:0]        out_old_tag;

    // 125 MHz: 8 time units per period.
    always #4 clk = ~clk;

    rename_unit #(
        .WIDTH(W), .ARCH_REGS(AR), .PHYS_REGS(PR), .ROB_DEPTH(RD),
        .WB_PORTS(2), .RET_PORTS(2)
    ) u_rename_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
        .in_dst(in_dst), .rob_free(rob_free), .wb_valid(wb_valid),
        .wb_tag(wb_tag), .ret_valid(ret_valid), .ret_tag(ret_tag),
        .stall(stall), .out_valid(out_valid), .out_seq(out_seq),
        .out_src_tag(out_src_tag), .out_src_avail(out_src_avail),
        .out_dst_tag(out_dst_tag), .out_old_tag(out_old_tag)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Sequential reference state.
    int m_rat [AR];
    bit m_rdy [PR];
    int m_fl  [FLD];
    int m_head, m_cnt, m_seq;
    int pend [64];
    int p_head, p_cnt;

    // Expected outputs of the current cycle.
    bit e_stall;
    bit e_valid [W];
    int e_seq [W];
    int e_tag [W][NS];
    bit e_av  [W][NS];
    string e_kind [W][NS];
    int e_dst [W];
    int e_old [W];
    int n_rat [AR];
    int e_need, e_nv;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_in();
        in_valid = '0; in_src = '0; in_dst = '0; rob_free = 4'd8;
        wb_valid = '0; wb_tag = '0; ret_valid = '0; ret_tag = '0;
    endtask

    task automatic set_op(input int i, input int a, input int b, input int c, input int d);
        in_valid[i]  = 1'b1;
        in_src[i][0] = 3'(a); in_src[i][1] = 3'(b); in_src[i][2] = 3'(c);
        in_dst[i]    = 3'(d);
    endtask

    task automatic give_back(input int port);
        if (p_cnt > 0) begin
            ret_valid[port] = 1'b1;
            ret_tag[port]   = 4'(pend[p_head]);
            p_head = (p_head + 1) % 64;
            p_cnt--;
        end
    endtask

    task automatic model_reset();
        for (int a = 0; a < AR; a++) m_rat[a] = a;
        for (int t = 0; t < PR; t++) m_rdy[t] = 1'b1;
        for (int k = 0; k < FLD; k++) m_fl[k] = AR + k;
        m_head = 0; m_cnt = FLD; m_seq = 0; p_head = 0; p_cnt = 0;
    endtask

    // Rename the slots one at a time against a scratch copy of the table.
    task automatic model_eval();
        bit fresh [AR];
        int k, v, a, d;
        for (int r = 0; r < AR; r++) begin n_rat[r] = m_rat[r]; fresh[r] = 0; end
        e_need = 0; e_nv = 0;
        for (int i = 0; i < W; i++) begin
            if (in_valid[i]) e_nv++;
            if (in_valid[i] && in_dst[i] != 0) e_need++;
        end
        e_stall = (e_need > m_cnt) || (e_nv > int'(rob_free));
        k = 0; v = 0;
        for (int i = 0; i < W; i++) begin
            e_valid[i] = in_valid[i] && !e_stall;
            e_seq[i] = (m_seq + v) % RD;
            if (in_valid[i]) v++;
            for (int s = 0; s < NS; s++) begin
                a = int'(in_src[i][s]);
                if (a == 0) begin
                    e_tag[i][s] = 0; e_av[i][s] = 1; e_kind[i][s] = "R6";
                end else begin
                    e_tag[i][s] = n_rat[a];
                    e_av[i][s]  = fresh[a] ? 1'b0 : m_rdy[n_rat[a]];
                    e_kind[i][s] = fresh[a] ? "R5" : "R3";
                end
            end
            d = int'(in_dst[i]);
            e_old[i] = n_rat[d];
            if (in_valid[i] && d != 0) begin
                e_dst[i] = m_fl[(m_head + k) % FLD];
                n_rat[d] = e_dst[i];
                fresh[d] = 1;
                k++;
            end else begin
                e_dst[i] = 0;
            end
        end
    endtask

    task automatic compare();
        chk("R7 stall", int'(stall), int'(e_stall));
        for (int i = 0; i < W; i++) begin
            chk("R7 out_valid", int'(out_valid[i]), int'(e_valid[i]));
            if (e_valid[i]) begin
                chk("R2 seq", int'(out_seq[i]), e_seq[i]);
                for (int s = 0; s < NS; s++) begin
                    chk({e_kind[i][s], " src tag"}, int'(out_src_tag[i][s]), e_tag[i][s]);
                    chk({e_kind[i][s], "/R8 src avail"}, int'(out_src_avail[i][s]), int'(e_av[i][s]));
                end
                chk("R4 dst tag", int'(out_dst_tag[i]), e_dst[i]);
                chk("R9 old tag", int'(out_old_tag[i]), e_old[i]);
            end
        end
    endtask

    task automatic model_commit();
        for (int p = 0; p < 2; p++)
            if (wb_valid[p]) m_rdy[int'(wb_tag[p])] = 1'b1;
        if (!e_stall) begin
            for (int i = 0; i < W; i++) begin
                if (in_valid[i] && in_dst[i] != 0) begin
                    m_rdy[e_dst[i]] = 1'b0;
                    pend[(p_head + p_cnt) % 64] = e_old[i];
                    p_cnt++;
                end
            end
            for (int r = 0; r < AR; r++) m_rat[r] = n_rat[r];
            m_head = (m_head + e_need) % FLD;
            m_cnt  = m_cnt - e_need;
            m_seq  = (m_seq + e_nv) % RD;
        end
        for (int p = 0; p < 2; p++) begin
            if (ret_valid[p]) begin
                m_fl[(m_head + m_cnt) % FLD] = int'(ret_tag[p]);
                m_cnt++;
            end
        end
    endtask

    task automatic settle();
        #2;
        model_eval();
        compare();
    endtask

    task automatic advance();
        model_commit();
        @(negedge clk);
    endtask

    initial begin
        int got;
        clear_in();
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: identity mapping, all ready, sequence starts at 0.
        set_op(0, 1, 2, 3, 0); set_op(1, 4, 5, 6, 0); set_op(2, 7, 1, 2, 0);
        settle();
        chk("R1 reset map", int'(out_src_tag[1][2]), 6);
        chk("R1 reset ready", int'(out_src_avail[2][0]), 1);
        chk("R1 first seq", int'(out_seq[0]), 0);
        advance();

        // R5 / R9 / R4: chained writes inside one group.
        clear_in();
        set_op(0, 1, 2, 0, 3); set_op(1, 3, 0, 0, 0); set_op(2, 3, 5, 0, 3);
        settle();
        chk("R4 first free tag", int'(out_dst_tag[0]), AR);
        chk("R5 fwd tag", int'(out_src_tag[1][0]), AR);
        chk("R5 fwd busy", int'(out_src_avail[2][0]), 0);
        chk("R9 old in group", int'(out_old_tag[2]), AR);
        chk("R4 second free tag", int'(out_dst_tag[2]), AR + 1);
        advance();

        // R8: a tag written back is ready the cycle after, not before.
        clear_in();
        set_op(0, 3, 0, 0, 0);
        wb_valid[0] = 1'b1; wb_tag[0] = 4'(AR + 1);
        settle();
        chk("R8 busy before wb", int'(out_src_avail[0][0]), 0);
        advance();
        clear_in();
        set_op(0, 3, 0, 0, 0);
        settle();
        chk("R8 ready after wb", int'(out_src_avail[0][0]), 1);
        advance();

        // R6: zero register as source and destination.
        clear_in();
        set_op(0, 0, 0, 0, 0); set_op(1, 0, 4, 0, 0);
        settle();
        chk("R6 zero dst", int'(out_dst_tag[0]), 0);
        advance();
        clear_in();
        set_op(0, 0, 0, 0, 2);
        settle();
        chk("R6 no tag consumed", int'(out_dst_tag[0]), AR + 2);
        advance();

        // R7: ROB short by one stalls and holds the sequence number.
        clear_in();
        set_op(0, 1, 0, 0, 4); set_op(1, 2, 0, 0, 0); set_op(2, 4, 0, 0, 5);
        rob_free = 4'd2;
        settle();
        chk("R7 rob stall", int'(stall), 1);
        got = m_seq;
        advance();
        rob_free = 4'd8;
        settle();
        chk("R7 seq held", int'(out_seq[0]), got);
        advance();

        // R10: drain the free list, then return and allocate in one cycle.
        while (m_cnt > 0) begin
            clear_in();
            set_op(0, 0, 0, 0, 6);
            settle();
            advance();
        end
        clear_in();
        set_op(0, 1, 0, 0, 7);
        got = pend[p_head];
        give_back(0);
        settle();
        chk("R10 same-cycle return stalls", int'(stall), 1);
        advance();
        clear_in();
        set_op(0, 1, 0, 0, 7);
        settle();
        chk("R10 returned tag used", int'(out_dst_tag[0]), got);
        advance();

        // Random sweep over all functions together.
        for (int n = 0; n < 4000; n++) begin
            clear_in();
            for (int i = 0; i < W; i++) begin
                if ($urandom_range(3) != 0)
                    set_op(i, $urandom_range(7), $urandom_range(7),
                           $urandom_range(7), $urandom_range(7));
            end
            rob_free = ($urandom_range(4) == 0) ? 4'($urandom_range(3)) : 4'd8;
            for (int p = 0; p < 2; p++) begin
                wb_valid[p] = 1'($urandom_range(1));
                wb_tag[p]   = 4'($urandom_range(PR - 1));
                if ($urandom_range(2) != 0) give_back(p);
            end
            settle();
            advance();
        end

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL R7 watchdog expired act=1 exp=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule